// File: doc/BRIEF.md
# Page Buffer Cursor Reader

This block sits between a NAND controller's 16-bit wide page buffer RAM and the logic that consumes page, spare or status data. It keeps a byte cursor into the buffer. Each accepted read request fetches the word under the cursor over a read port with one cycle of latency. It then returns either one byte or one halfword on an output that is valid for a single cycle.

The most recent command decides where the cursor starts. The choices are the main area, the spare area, the middle of the page, or address zero for a status read. With an 8-bit device bus, each word is returned as two bytes, low half first, and the cursor moves on only after the high half. With a 16-bit device bus, each word is returned whole. A split-spare mode handles spare data held in 16-byte chunks at a 32-byte stride. In that mode the cursor steps over the gaps between chunks, and it jumps from the end of the main area into the spare area. A cursor beyond the last valid address produces an error item instead of a RAM read.

Top module: `pbuf_cursor_reader`

## Requirements
- R1: After reset the cursor equals the main base 0x100, the byte phase is low, out_valid is 0 and rd_ready is 1.
- R2: A read is accepted in a cycle where rd_req and rd_ready are 1 and cmd_valid is 0. Its item appears with out_valid high for exactly one cycle, two clock edges after acceptance. rd_ready is low in the cycle between.
- R3: With wide_bus=0, the first read at a cursor returns word bits 7:0 on out_data[7:0], with out_data[15:8] zero, and leaves the cursor unchanged. The second read returns bits 15:8 and then advances the cursor.
- R4: With wide_bus=1, each read returns the full 16-bit word and advances the cursor.
- R5: An accepted command clears the byte phase and loads the cursor according to cmd_kind. Code 0 loads the main base 0x100. Code 1 (spare) loads 0xC00. Code 2 (second half) loads 0x100 + 1024 = 0x500. Code 3 (status) loads 0x000.
- R6: A read accepted while the cursor is above 0xC6F returns out_data 0 with out_err 1. It does not enable the RAM, leaves the cursor unchanged and clears the byte phase.
- R7: With split_spare=0, advancing the cursor adds 2, with no jumps.
- R8: With split_spare=1, an advance that would reach 0x900 (main base plus page size) loads 0xC00 instead.
- R9: With split_spare=1, an advanced address that is above 0xC00 and has low five bits equal to 16 moves ahead by 16 more, to the next 32-byte-aligned chunk.
- R10: When cmd_valid and rd_req are both 1 in the same cycle, the command takes effect and the read is dropped: no item is produced.
- R11: ram_addr is the cursor's byte address shifted right by one. The fetched word is the one under the cursor at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_bus | input | 1 | 1: halfword items, 0: byte items |
| split_spare | input | 1 | Enables chunked spare stepping and the main-to-spare jump |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | 0 main, 1 spare, 2 second half, 3 status |
| rd_req | input | 1 | Request the next item |
| rd_ready | output | 1 | No read in flight; a request can be accepted |
| ram_en | output | 1 | Buffer RAM read enable |
| ram_addr | output | 11 | Buffer RAM word address |
| ram_rdata | input | 16 | Buffer RAM read data, one cycle after ram_en |
| out_valid | output | 1 | Item valid, one cycle per accepted read |
| out_data | output | 16 | Byte (zero-extended) or halfword |
| out_err | output | 1 | Item is an overrun error |
| cursor | output | 12 | Current byte cursor |

## Verification
A read accepted at one clock edge moves the cursor and byte phase at that same edge. Its item is due after the second edge, and out_valid must be low after the first. The bench samples at the falling edge after each of those edges, so that it checks both the early cursor update and the late item. A command's cursor load is due one edge after cmd_valid is sampled, and it is checked at the following falling edge. Expected data comes from a bench function of the word address and from a bench cursor model built from the requirements. Mode changes are made only between operations.

// File: rtl/pbuf_cursor_reader.sv
module pbuf_cursor_reader #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int PAGE_BYTES = 2048,
  parameter int CHUNK_LEN = 16,
  parameter int CHUNK_STRIDE = 32,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 12'h100,
  parameter logic [ADDR_W-1:0] SPARE_BASE = 12'hC00,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 12'hC6F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_bus,
  input  logic              split_spare,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic              rd_req,
  output logic              rd_ready,
  output logic              ram_en,
  output logic [ADDR_W-2:0] ram_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err,
  output logic [ADDR_W-1:0] cursor
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LOW_W = $clog2(CHUNK_STRIDE);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] MAIN_END = ADDR_W'(MAIN_BASE + PAGE_BYTES);
  localparam logic [ADDR_W-1:0] HALF_PAGE = ADDR_W'(MAIN_BASE + PAGE_BYTES / 2);
  localparam logic [ADDR_W-1:0] GAP = ADDR_W'(CHUNK_STRIDE - CHUNK_LEN);
  localparam logic [LOW_W-1:0] CHUNK_END = LOW_W'(CHUNK_LEN);

  logic pend, phase, sel_hi, p_wide, p_err;
  logic [ADDR_W-1:0] inc, nxt, start;

  assign rd_ready = ~pend;
  wire rd_fire = rd_req & ~pend & ~cmd_valid;
  wire over = cursor > LAST_ADDR;
  assign ram_en = rd_fire & ~over;
  assign ram_addr = cursor[ADDR_W-1:1];
  assign inc = cursor + STEP;

  always_comb begin
    nxt = inc;
    if (split_spare) begin
      if (inc == MAIN_END) nxt = SPARE_BASE;
      else if (inc > SPARE_BASE && inc[LOW_W-1:0] == CHUNK_END) nxt = inc + GAP;
    end
  end

  always_comb begin
    case (cmd_kind)
      2'd1:    start = SPARE_BASE;
      2'd2:    start = HALF_PAGE;
      2'd3:    start = '0;
      default: start = MAIN_BASE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cursor <= MAIN_BASE;
      phase <= 1'b0;
      pend <= 1'b0;
      sel_hi <= 1'b0;
      p_wide <= 1'b0;
      p_err <= 1'b0;
      out_valid <= 1'b0;
      out_data <= '0;
      out_err <= 1'b0;
    end else begin
      out_valid <= pend;
      pend <= rd_fire;
      if (pend) begin
        out_err <= p_err;
        if (p_err) out_data <= '0;
        else if (p_wide) out_data <= ram_rdata;
        else out_data <= {{HALF_W{1'b0}}, sel_hi ? ram_rdata[DATA_W-1:HALF_W] : ram_rdata[HALF_W-1:0]};
      end else begin
        out_err <= 1'b0;
      end
      if (cmd_valid) begin
        cursor <= start;
        phase <= 1'b0;
      end else if (rd_fire) begin
        p_err <= over;
        p_wide <= wide_bus;
        sel_hi <= phase & ~wide_bus;
        if (over) phase <= 1'b0;
        else if (wide_bus || phase) begin
          cursor <= nxt;
          phase <= 1'b0;
        end else phase <= 1'b1;
      end
    end
  end

  // R2
  item_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ready && !cmd_valid |=> !out_valid ##1 out_valid);
  // R2
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid && out_data == '0);
  // R6
  over_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ready && !cmd_valid && cursor > LAST_ADDR |=> cursor == $past(cursor));
  // R11
  ram_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |=> ##1 out_valid && !out_err);
  // R5
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_kind == 2'd3 |=> cursor == '0);
endmodule

// File: tb/tb_pbuf_cursor_reader.sv
module tb_pbuf_cursor_reader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wide_bus = 1'b0, split_spare = 1'b0, cmd_valid = 1'b0, rd_req = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic rd_ready, ram_en, out_valid, out_err;
  logic [10:0] ram_addr;
  logic [15:0] ram_rdata = '0, out_data;
  logic [11:0] cursor;
  int checks = 0, bad = 0;
  logic [11:0] mcur;
  logic mph;

  always #2.5 clk = ~clk;

  pbuf_cursor_reader dut (.clk(clk), .rst_n(rst_n), .wide_bus(wide_bus), .split_spare(split_spare),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .rd_req(rd_req), .rd_ready(rd_ready),
    .ram_en(ram_en), .ram_addr(ram_addr), .ram_rdata(ram_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_err(out_err), .cursor(cursor));

  function automatic logic [15:0] word_of(input logic [10:0] a);
    logic [15:0] w;
    w = 16'({a, 5'b0}) ^ 16'(a * 16'h9E37) ^ 16'h3C5A;
    return w;
  endfunction

  always_ff @(posedge clk) if (ram_en) ram_rdata <= word_of(ram_addr);

  function automatic logic [11:0] start_of(input logic [1:0] k);
    case (k)
      2'd1: return 12'hC00;
      2'd2: return 12'h500;
      2'd3: return 12'h000;
      default: return 12'h100;
    endcase
  endfunction

  function automatic logic [11:0] adv(input logic [11:0] c, input logic sp);
    logic [11:0] n;
    n = c + 12'd2;
    if (sp && n == 12'h900) return 12'hC00;
    if (sp && n > 12'hC00 && n[4:0] == 5'd16) return n + 12'd16;
    return n;
  endfunction

  task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] k);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k;
    @(negedge clk);
    cmd_valid = 1'b0;
    mcur = start_of(k); mph = 1'b0;
    check(cursor == mcur, "R5", "cursor after command", cursor, mcur);
  endtask

  task automatic do_read(input string req);
    logic [15:0] w, ed;
    logic ee;
    logic [11:0] ncur;
    @(negedge clk);
    rd_req = 1'b1;
    w = word_of(mcur[11:1]);
    ee = mcur > 12'hC6F;
    ncur = mcur;
    if (ee) begin ed = 16'h0; mph = 1'b0; end
    else if (wide_bus) begin ed = w; ncur = adv(mcur, split_spare); end
    else if (mph) begin ed = {8'h0, w[15:8]}; ncur = adv(mcur, split_spare); mph = 1'b0; end
    else begin ed = {8'h0, w[7:0]}; mph = 1'b1; end
    mcur = ncur;
    @(negedge clk);
    rd_req = 1'b0;
    check(!out_valid && !rd_ready, "R2", "mid cycle valid/ready", {out_valid, rd_ready}, 0);
    check(cursor == mcur, req, "cursor after read", cursor, mcur);
    @(negedge clk);
    check(out_valid, "R2", "item valid", out_valid, 1);
    check(out_data == ed, req, "item data", out_data, ed);
    check(out_err == ee, "R6", "item error flag", out_err, ee);
  endtask

  initial begin
    #(5.0 * 190000);
    bad++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mcur = 12'h100; mph = 1'b0;
    check(cursor == 12'h100, "R1", "reset cursor", cursor, 12'h100);
    check(!out_valid && rd_ready, "R1", "reset valid/ready", {out_valid, rd_ready}, 1);

    // R3 byte ordering from main base, R11 word fetch
    do_read("R3"); do_read("R3"); do_read("R3");
    // R5 command clears phase mid-word
    do_cmd(2'd3); do_read("R5"); do_read("R3");
    do_cmd(2'd2); do_read("R5");
    // R4 halfword mode
    wide_bus = 1'b1;
    do_cmd(2'd0); do_read("R4"); do_read("R4");
    // R9 chunk skip and R6 overrun in split mode
    split_spare = 1'b1;
    do_cmd(2'd1);
    for (int i = 0; i < 8; i++) do_read("R9");
    check(cursor == 12'hC20, "R9", "cursor after first chunk", cursor, 12'hC20);
    for (int i = 0; i < 26; i++) do_read("R6");
    check(cursor == 12'hC80, "R6", "cursor held past bound", cursor, 12'hC80);
    // R8 main end jumps to spare
    do_cmd(2'd2);
    for (int i = 0; i < 512; i++) do_read("R8");
    check(cursor == 12'hC00, "R8", "cursor after main end", cursor, 12'hC00);
    // R7 plain stepping through main end and into overrun
    split_spare = 1'b0;
    do_cmd(2'd2);
    for (int i = 0; i < 512; i++) do_read("R7");
    check(cursor == 12'h900, "R7", "cursor past main end", cursor, 12'h900);
    do_cmd(2'd1);
    for (int i = 0; i < 58; i++) do_read("R7");
    // R6 byte mode overrun clears phase
    wide_bus = 1'b0;
    do_read("R6"); do_read("R6");
    // R10 command beats a simultaneous read
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 2'd3; rd_req = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; rd_req = 1'b0;
    mcur = 12'h000; mph = 1'b0;
    check(cursor == 12'h000 && rd_ready, "R10", "cursor/ready after clash", cursor, 0);
    @(negedge clk);
    check(!out_valid, "R10", "dropped read gives no item", out_valid, 0);
    @(negedge clk);
    check(!out_valid, "R10", "dropped read gives no item later", out_valid, 0);
    do_read("R3");

    for (int i = 0; i < 1500; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) do_cmd(2'($urandom % 4));
      else if (r == 1) begin
        wide_bus = 1'($urandom); split_spare = 1'($urandom);
        do_cmd(2'($urandom % 4));
      end else do_read("R11");
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule